// File: doc/BRIEF.md
# Radix-4 Multiplexer-Tree Left Shifter

This block shifts a data word left by a variable amount. The amount is a binary number from zero up to one less than the word width. Bits that move past the most significant position are dropped, and the positions they leave empty at the low end are filled with zeros. The logic is built only from four-input selectors arranged in radix-4 stages. With the default 16-bit width there are exactly two stages.

The coarse stage comes first. It reads the two upper bits of the shift amount and moves the word by 0, 4, 8 or 12 places. The fine stage follows. It reads the two lower bits and moves the word a further 0, 1, 2 or 3 places. Each stage holds one four-input selector per output bit, so the default build has 32 selectors in total and no other gates on the data path. At 2 ns per selector the two-stage path settles in 4 ns.

An optional output register follows the combinational tree to help with timing, and it is enabled by default. When it is enabled, the result appears one clock after the inputs, and an active-low asynchronous reset clears it.

Top module: `shl_mux_tree`

## Requirements
- R1: With the output register enabled, `dout` equals `din` multiplied by 2 to the power `sh`, reduced modulo 2^16, one clock edge after `din` and `sh` are applied.
- R2: Output bits at positions below `sh` are always 0.
- R3: When `sh` is 0, the result equals `din` unchanged.
- R4: When `sh[1:0]` is 0, the shift is exactly 4 times `sh[3:2]` places. The coarse stage alone performs it.
- R5: When `sh[3:2]` is 0, the shift is exactly `sh[1:0]` places. The fine stage alone performs it.
- R6: While `rst_n` is low, `dout` is 0.
- R7: Input bits that move past bit 15 are lost. For example, `din` = 16'h8000 with any nonzero `sh` gives 0.
- R8: The result never has more set bits than `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| din | input | 16 | Data word to be shifted |
| sh | input | 4 | Left shift amount, 0 to 15 |
| dout | output | 16 | Shifted result |

## Verification
The assertions assume that `din` and `sh` hold steady across each rising clock edge and are never X or Z outside reset. The checks between stages also assume the coarse stage reads the upper half of `sh` and the fine stage reads the lower half. The bench changes its inputs only on the falling edge, always drives known values, and sweeps every shift amount. Each sweep covers all zeros, all ones, single set bits at both ends, alternating patterns and random words, so every selector leg that carries real data is exercised and so is every leg tied to zero.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int unsigned MUX_WAYS = 4;
  localparam int unsigned SEL_W    = 2;

  typedef logic [SEL_W-1:0] sel_t;

  // Distance moved by one selector step in a given radix-4 level.
  function automatic int unsigned level_step(input int unsigned lvl);
    int unsigned s;
    s = 1;
    for (int unsigned i = 0; i < lvl; i++) s = s * MUX_WAYS;
    return s;
  endfunction

  // Number of radix-4 levels needed for a shift-amount width.
  function automatic int unsigned level_count(input int unsigned shw);
    return (shw + SEL_W - 1) / SEL_W;
  endfunction
endpackage

// File: rtl/shl_mux4.sv
module shl_mux4
  import shl_pkg::*;
(
  input  logic [MUX_WAYS-1:0] a,
  input  sel_t                sel,
  output logic                y
);
  always_comb begin
    case (sel)
      2'd0:    y = a[0];
      2'd1:    y = a[1];
      2'd2:    y = a[2];
      default: y = a[3];
    endcase
  end
endmodule

// File: rtl/shl_stage.sv
module shl_stage
  import shl_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned STEP  = 1
) (
  input  logic [WIDTH-1:0] d,
  input  sel_t             sel,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0][MUX_WAYS-1:0] legs;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    for (genvar j = 0; j < MUX_WAYS; j++) begin : g_leg
      if (k >= j * STEP) begin : g_src
        assign legs[k][j] = d[k - j * STEP];
      end else begin : g_zero
        assign legs[k][j] = 1'b0;
      end
    end
    shl_mux4 u_mux (
      .a  (legs[k]),
      .sel(sel),
      .y  (q[k])
    );
  end
endmodule

// File: rtl/shl_mux_tree.sv
module shl_mux_tree
  import shl_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         din,
  input  logic [$clog2(WIDTH)-1:0] sh,
  output logic [WIDTH-1:0]         dout
);
  localparam int unsigned SHW    = $clog2(WIDTH);
  localparam int unsigned LEVELS = level_count(SHW);

  // chain[LEVELS] is the input; chain[0] is the fully shifted word.
  logic [WIDTH-1:0] chain [LEVELS+1];
  logic [WIDTH-1:0] coarse_w;  // after the first (highest) level
  logic [WIDTH-1:0] res_w;     // combinational result

  assign chain[LEVELS] = din;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    shl_stage #(
      .WIDTH(WIDTH),
      .STEP (level_step(g))
    ) u_stage (
      .d  (chain[g+1]),
      .sel(sh[SEL_W*g +: SEL_W]),
      .q  (chain[g])
    );
  end

  assign coarse_w = chain[LEVELS-1];
  assign res_w    = chain[0];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else        dout <= res_w;
    end
  end else begin : g_comb
    assign dout = res_w;
  end
endmodule

// File: rtl/shl_mux_tree_chk.sv
module shl_mux_tree_chk #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         din,
  input logic [$clog2(WIDTH)-1:0] sh,
  input logic [WIDTH-1:0]         coarse_w,
  input logic [WIDTH-1:0]         res_w,
  input logic [WIDTH-1:0]         dout
);
  localparam int unsigned SHW = $clog2(WIDTH);

  logic [WIDTH-1:0] coarse_exp, fine_exp, low_mask;
  assign coarse_exp = din << {sh[SHW-1:SHW-2], 2'b00};
  assign fine_exp   = coarse_w << sh[1:0];
  assign low_mask   = ~({WIDTH{1'b1}} << sh);

  p_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_w & low_mask) == '0);
  p_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sh == '0) |-> (res_w == din));
  p_coarse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_w == coarse_exp);
  p_fine_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_w == fine_exp);
  p_popcount_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(res_w) <= $countones(din));

  if (REG_OUT) begin : g_reg_chk
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (dout == $past(res_w)));
    p_reset_r6: assert property (@(posedge clk)
      !rst_n |-> (dout == '0));
  end
endmodule

bind shl_mux_tree shl_mux_tree_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .din     (din),
  .sh      (sh),
  .coarse_w(coarse_w),
  .res_w   (res_w),
  .dout    (dout)
);

// File: tb/tb_shl_mux_tree.sv
`timescale 1ns/1ps
module tb_shl_mux_tree;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = 16'h1234;
  logic [3:0]  sh = 4'd5;
  logic [15:0] dout;

  int checks = 0;
  int errors = 0;
  int expq[$];
  int dinq[$];
  int shq[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  shl_mux_tree dut (.clk(clk), .rst_n(rst_n), .din(din), .sh(sh), .dout(dout));

  function automatic int ref_shift(input int d, input int s);
    int p;
    p = 1;
    for (int i = 0; i < s; i++) p = p * 2;
    return (d * p) % 65536;
  endfunction

  function automatic int ones(input int v);
    int c;
    c = 0;
    for (int i = 0; i < 16; i++) if (((v >> i) & 1) == 1) c++;
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare dout with the oldest pending expectation.
  task automatic compare_front();
    int e, d, s;
    string tag;
    e = expq.pop_front(); d = dinq.pop_front(); s = shq.pop_front();
    if (s == 0)                 tag = "R3";
    else if (d == 16'h8000)     tag = "R7";
    else if ((s % 4) == 0)      tag = "R4";
    else if (s < 4)             tag = "R5";
    else                        tag = "R1";
    check(tag, int'(dout), e);
    check("R2", int'(dout) % (1 << s), 0);
    check("R8", (ones(int'(dout)) <= ones(d)) ? 1 : 0, 1);
  endtask

  task automatic apply(input int d, input int s);
    @(negedge clk);
    if (expq.size() > 0) compare_front();
    din = d[15:0];
    sh  = s[3:0];
    expq.push_back(ref_shift(d, s));
    dinq.push_back(d);
    shq.push_back(s);
  endtask

  task automatic sweep(input int d);
    for (int s = 0; s < 16; s++) apply(d, s);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6", int'(dout), 0);
    rst_n = 1'b1;

    sweep(16'h0000);
    sweep(16'hFFFF);
    sweep(16'h0001);
    sweep(16'h8000);
    sweep(16'hA5A5);
    sweep(16'h5A5A);
    for (int r = 0; r < 8; r++) sweep(int'($urandom_range(0, 65535)));
    @(negedge clk);
    compare_front();

    // Reset in mid-run clears the registered result.
    din = 16'hFFFF; sh = 4'd0;
    @(negedge clk);
    check("R1", int'(dout), 16'hFFFF);
    rst_n = 1'b0;
    #1;
    check("R6", int'(dout), 0);
    @(negedge clk);
    check("R6", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", int'(dout), 16'hFFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule